// File: doc/BRIEF.md
# Serial-Addressed GPIO Port Expander Core

This block is the register side of an eight-pin general-purpose I/O expander reached over a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge, shifted out on the falling edge, most significant bit first). Every transaction opens with a command byte. Its upper nibble is a fixed device code (0100). Bits 3:1 are a three-bit device sub-address, and bit 0 is a direction flag (1 = read). The second byte selects a register. Any further bytes are data that stream into or out of an eleven-entry register bank. The register pointer may step forward after each byte.

Several expanders may share one chip select. Each one compares the sub-address in the command byte against its strap inputs `dev_sel`, but only when the sub-address enable bit of its configuration register is set. An expander that does not match ignores the rest of the frame and leaves its MISO driver off. The bank drives the pads: direction, output latch, pull-up enable, and input polarity for read-back. It also holds the enable, compare and mode bytes that a separate change-detect block consumes, and it returns that block's flag and capture bytes on reads. The SPI pins are sampled by the block clock, so SCK must run several times slower than `clk`.

Top module: `spx_port_expander`

## Requirements
- R1: After reset every pad is an input (`pad_oe` = 0x00, direction register = 0xFF), every other stored register is 0x00, and `spi_miso_oe` is low.
- R2: A command byte whose bits 7:4 are not 0100 makes the device ignore the whole frame: no register changes and MISO is not driven.
- R3: With configuration bit 3 set, only a command whose bits 3:1 equal `dev_sel` is served. With bit 3 clear, any sub-address is served.
- R4: In a write frame, the byte after the register byte is stored in the addressed register.
- R5: In a read frame, register data leaves MSB first on `spi_miso`, changing after SCK falls. `spi_miso_oe` is high only during the data bytes of a served read.
- R6: With configuration bit 5 clear, the pointer steps after each data byte and wraps from 0x0A to 0x00. With bit 5 set, the pointer stays put. The step taken at the end of a byte uses the configuration in force before that byte's own write.
- R7: Register addresses above 0x0A read as 0x00 and ignore writes, and the next sequential step from them goes to 0x00.
- R8: `pad_oe` is the inverse of the direction register (0x00), `pad_out` is the output latch (0x0A), and `pad_pull_en` is the pull-up register (0x06).
- R9: Reading address 0x09 returns the synchronised pad levels XOR the polarity register (0x01). Writing 0x09 loads the output latch.
- R10: Addresses 0x07 and 0x08 return `irq_flag_in` and `irq_cap_in`, and writes to them change nothing.
- R11: Raising chip select mid-byte discards the partial byte, and the next frame starts again with a command byte.
- R12: `irq_enable`, `irq_compare`, `irq_mode` and `cfg_bits` show registers 0x02, 0x03, 0x04 and 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Shared chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | MISO driver enable (low = tri-state) |
| dev_sel | input | 3 | Strapped sub-address |
| pad_in | input | 8 | Pad levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pull_en | output | 8 | Pad pull-up enables |
| irq_flag_in | input | 8 | Flag byte from the change-detect block |
| irq_cap_in | input | 8 | Capture byte from the change-detect block |
| irq_enable | output | 8 | Change-detect enable register |
| irq_compare | output | 8 | Change-detect compare register |
| irq_mode | output | 8 | Change-detect mode register |
| cfg_bits | output | 8 | Configuration register |

## Verification
The risky coincidence is a write to the configuration register that sets the no-increment bit, because the pointer step for that same byte happens on the same clock edge. The bench provokes it with a four-byte write burst that starts at the mode register. The second byte sets bit 5, and the third and fourth bytes must both land in the pull-up register, so the last value wins there. A second coincidence is the load of the next read byte on the same edge as the pointer step. Wrapping bursts from 0x09 over 0x0A back to 0x00 compare every byte against values computed from the bench's own register model.

// File: rtl/spx_pkg.sv
// Package: shared register addresses, configuration bit positions and
// frame phases for the serial-addressed port expander.
package spx_pkg;

    // Register addresses; the pointer order is behaviour (sequential bursts)
    typedef enum logic [3:0] {
        RA_DIR   = 4'd0,
        RA_POL   = 4'd1,
        RA_IEN   = 4'd2,
        RA_CMP   = 4'd3,
        RA_ICTL  = 4'd4,
        RA_CFG   = 4'd5,
        RA_PULL  = 4'd6,
        RA_FLAG  = 4'd7,
        RA_CAP   = 4'd8,
        RA_PORT  = 4'd9,
        RA_LATCH = 4'd10
    } reg_addr_e;

    localparam int unsigned NUM_REGS       = 11;
    localparam int unsigned CFG_NOSEQ_BIT  = 5;
    localparam int unsigned CFG_SUBADR_BIT = 3;
    localparam logic [3:0]  DEV_CODE       = 4'b0100;

    // Frame phases of one chip-select window
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

endpackage

// File: rtl/spx_sync.sv
// Module: spx_sync
// Multi-stage synchroniser for asynchronous inputs into the clk domain.
// Assumes inputs are quasi-static relative to clk (slow SPI, pads).
module spx_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: shift the input one stage closer to the clk domain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st[g] <= RST_VAL;
                end else if (g == 0) begin
                    st[g] <= d;
                end else begin
                    st[g] <= st[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];

endmodule

// File: rtl/spx_serial_frame.sv
// Module: spx_serial_frame
// SPI mode-0 slave framer: assembles bytes, decodes the command byte
// (device code, sub-address, read flag), holds the register pointer
// and produces register-bank read/write strobes and the MISO stream.
// Assumes sck/cs_n/mosi are already synchronised to clk and that SCK
// is slow enough for every edge to be seen.
module spx_serial_frame
    import spx_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned AW   = 8,
    parameter int unsigned LAST = NUM_REGS - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          cs_n_s,
    input  logic          mosi_s,
    input  logic [2:0]    dev_sel,
    input  logic          cfg_subadr,
    input  logic          cfg_noseq,
    input  logic [W-1:0]  rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          miso,
    output logic          miso_oe
);

    localparam int unsigned BCW = $clog2(W);

    logic           sck_q;
    logic           cs_act;
    logic           sck_rise;
    logic           sck_fall;
    logic           byte_done;
    logic [BCW-1:0] bit_cnt_q;
    logic [W-1:0]   rx_q;
    logic [W-1:0]   rx_full;
    logic [W-1:0]   tx_q;
    logic [AW-1:0]  ptr_q;
    logic [AW-1:0]  ptr_step;
    logic [AW-1:0]  ptr_adv;
    logic           is_rd_q;
    logic           cmd_ok;
    phase_e         phase_q;

    // Purpose: edge detection and byte assembly signals
    always_comb begin
        cs_act    = !cs_n_s;
        sck_rise  = cs_act && sck_s && !sck_q;
        sck_fall  = cs_act && !sck_s && sck_q;
        rx_full   = {rx_q[W-2:0], mosi_s};
        byte_done = sck_rise && (bit_cnt_q == BCW'(W-1));
        cmd_ok    = (rx_full[7:4] == DEV_CODE) &&
                    (!cfg_subadr || (rx_full[3:1] == dev_sel));
    end

    // Purpose: next pointer value with wrap and no-increment option
    always_comb begin
        ptr_step = (ptr_q >= AW'(LAST)) ? '0 : ptr_q + AW'(1);
        ptr_adv  = cfg_noseq ? ptr_q : ptr_step;
        rd_addr  = (phase_q == PH_ADDR) ? rx_full : ptr_adv;
    end

    // Purpose: remember the previous synchronised SCK level
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Purpose: bit counter, receive shifter, phase, read flag and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            phase_q   <= PH_CMD;
            is_rd_q   <= 1'b0;
            ptr_q     <= '0;
        end else if (!cs_act) begin
            bit_cnt_q <= '0;
            phase_q   <= PH_CMD;
            is_rd_q   <= 1'b0;
            ptr_q     <= '0;
        end else if (sck_rise) begin
            rx_q      <= rx_full;
            bit_cnt_q <= bit_cnt_q + BCW'(1);
            if (byte_done) begin
                unique case (phase_q)
                    PH_CMD: begin
                        if (cmd_ok) begin
                            phase_q <= PH_ADDR;
                            is_rd_q <= rx_full[0];
                        end else begin
                            phase_q <= PH_SKIP;
                        end
                    end
                    PH_ADDR: begin
                        ptr_q   <= rx_full;
                        phase_q <= PH_DATA;
                    end
                    PH_DATA: ptr_q   <= ptr_adv;
                    PH_SKIP: phase_q <= PH_SKIP;
                endcase
            end
        end
    end

    // Purpose: load read data at byte end, shift it out on SCK fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (byte_done && is_rd_q &&
                     (phase_q == PH_ADDR || phase_q == PH_DATA)) begin
            tx_q <= rd_data;
        end else if (sck_fall && (bit_cnt_q != '0)) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    // Purpose: write strobe and MISO drive
    always_comb begin
        wr_en   = byte_done && (phase_q == PH_DATA) && !is_rd_q;
        wr_addr = ptr_q;
        wr_data = rx_full;
        miso_oe = cs_act && (phase_q == PH_DATA) && is_rd_q;
        miso    = miso_oe ? tx_q[W-1] : 1'b0;
    end

    // R5: the transmit shifter only moves on SCK fall or a byte load
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !byte_done) |=> $stable(tx_q));

    // R6: sequential stepping past the last register wraps to zero
    p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase_q == PH_DATA && !cfg_noseq && ptr_q == AW'(LAST))
        |=> (ptr_q == '0));

    // R3: an unserved frame never writes nor drives MISO
    p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SKIP) |-> (!wr_en && !miso_oe));

    // R11: a released chip select restarts framing
    p_cs_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (phase_q == PH_CMD && bit_cnt_q == '0));

endmodule

// File: rtl/spx_regbank.sv
// Module: spx_regbank
// Eleven-entry register bank of the port expander. Stored entries are
// written by the framer; the flag, capture and port entries are views
// of inputs. A port write lands in the output latch. Assumes at most
// one write strobe per cycle.
module spx_regbank
    import spx_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic [W-1:0]  pad_lvl,
    input  logic [W-1:0]  flag_in,
    input  logic [W-1:0]  cap_in,
    output logic [W-1:0]  dir,
    output logic [W-1:0]  pol,
    output logic [W-1:0]  ien,
    output logic [W-1:0]  cmp,
    output logic [W-1:0]  ictl,
    output logic [W-1:0]  cfg,
    output logic [W-1:0]  pull,
    output logic [W-1:0]  latch
);

    logic [W-1:0]        view [NUM_REGS];
    logic [NUM_REGS-1:0] we_vec;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
            if (i == int'(RA_FLAG)) begin : g_flag
                assign view[i]   = flag_in;
                assign we_vec[i] = 1'b0;
            end else if (i == int'(RA_CAP)) begin : g_cap
                assign view[i]   = cap_in;
                assign we_vec[i] = 1'b0;
            end else if (i == int'(RA_PORT)) begin : g_port
                assign view[i]   = pad_lvl ^ pol;
                assign we_vec[i] = 1'b0;
            end else begin : g_store
                localparam logic [W-1:0] RST = (i == int'(RA_DIR)) ? '1 : '0;
                logic [W-1:0] val_q;
                // Latch entry also takes writes aimed at the port address
                if (i == int'(RA_LATCH)) begin : g_we_latch
                    assign we_vec[i] = wr_en &&
                        (wr_addr == AW'(i) || wr_addr == AW'(RA_PORT));
                end else begin : g_we_plain
                    assign we_vec[i] = wr_en && (wr_addr == AW'(i));
                end
                // Purpose: hold one stored register
                always_ff @(posedge clk) begin
                    if (!rst_n)         val_q <= RST;
                    else if (we_vec[i]) val_q <= wr_data;
                end
                assign view[i] = val_q;
            end
        end
    endgenerate

    // Purpose: named outputs of the stored entries
    always_comb begin
        dir   = view[RA_DIR];
        pol   = view[RA_POL];
        ien   = view[RA_IEN];
        cmp   = view[RA_CMP];
        ictl  = view[RA_ICTL];
        cfg   = view[RA_CFG];
        pull  = view[RA_PULL];
        latch = view[RA_LATCH];
    end

    // Purpose: read mux, out-of-range addresses read zero
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == AW'(k)) rd_data = view[k];
        end
    end

    // R4: a write strobe selects at most one stored entry
    p_wr_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    // R9: a port write appears in the output latch next cycle
    p_port_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AW'(RA_PORT)) |=> (latch == $past(wr_data)));

    // R10: writes to flag or capture addresses touch no stored entry
    p_ro_flag_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == AW'(RA_FLAG) || wr_addr == AW'(RA_CAP)))
        |-> (we_vec == '0));

endmodule

// File: rtl/spx_port_expander.sv
// Module: spx_port_expander
// Top of the serial-addressed GPIO port expander: synchronises the SPI
// and pad inputs, runs the framer and the register bank and drives the
// pad controls. Assumes SCK period of at least eight clk cycles.
module spx_port_expander
    import spx_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_sck,
    input  logic         spi_cs_n,
    input  logic         spi_mosi,
    output logic         spi_miso,
    output logic         spi_miso_oe,
    input  logic [2:0]   dev_sel,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pull_en,
    input  logic [W-1:0] irq_flag_in,
    input  logic [W-1:0] irq_cap_in,
    output logic [W-1:0] irq_enable,
    output logic [W-1:0] irq_compare,
    output logic [W-1:0] irq_mode,
    output logic [W-1:0] cfg_bits
);

    localparam int unsigned AW = 8;

    logic [2:0]   spi_s;
    logic [W-1:0] pad_s;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic [W-1:0]  rd_data;
    logic [W-1:0]  wr_data;
    logic          wr_en;
    logic [W-1:0]  dir;
    logic [W-1:0]  pol;
    logic [W-1:0]  latch;

    spx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_spi_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_sck, spi_cs_n, spi_mosi}),
        .q    (spi_s)
    );

    spx_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pad_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pad_s)
    );

    spx_serial_frame #(.W(W), .AW(AW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (spi_s[2]),
        .cs_n_s    (spi_s[1]),
        .mosi_s    (spi_s[0]),
        .dev_sel   (dev_sel),
        .cfg_subadr(cfg_bits[CFG_SUBADR_BIT]),
        .cfg_noseq (cfg_bits[CFG_NOSEQ_BIT]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    spx_regbank #(.W(W), .AW(AW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .pad_lvl(pad_s),
        .flag_in(irq_flag_in),
        .cap_in (irq_cap_in),
        .dir    (dir),
        .pol    (pol),
        .ien    (irq_enable),
        .cmp    (irq_compare),
        .ictl   (irq_mode),
        .cfg    (cfg_bits),
        .pull   (pad_pull_en),
        .latch  (latch)
    );

    // Purpose: pad drive from direction and latch
    always_comb begin
        pad_oe  = ~dir;
        pad_out = latch;
    end

    // R8: an input-direction pad is never driven
    p_pad_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pad_oe & dir) == 0);

endmodule

// File: tb/spx_port_expander_tb.sv
module spx_port_expander_tb;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic [2:0] dev_sel = 3'd5;
    logic [7:0] pad_in = 8'hA5;
    logic [7:0] pad_out, pad_oe, pad_pull_en;
    logic [7:0] irq_flag_in = 8'h3C;
    logic [7:0] irq_cap_in = 8'hC3;
    logic [7:0] irq_enable, irq_compare, irq_mode, cfg_bits;

    always #2 clk = ~clk;

    spx_port_expander u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .dev_sel(dev_sel), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .irq_flag_in(irq_flag_in), .irq_cap_in(irq_cap_in),
        .irq_enable(irq_enable), .irq_compare(irq_compare),
        .irq_mode(irq_mode), .cfg_bits(cfg_bits)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [7:0] mdl [0:10];
    logic [7:0] wbuf [0:15];
    logic [7:0] rbuf [0:15];
    logic       obuf [0:15];

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'd7)      return irq_flag_in;
        else if (a == 8'd8) return irq_cap_in;
        else if (a == 8'd9) return pad_in ^ mdl[1];
        else if (a > 8'd10) return 8'h00;
        else                return mdl[a[3:0]];
    endfunction

    function automatic logic accepts(input logic [7:0] cmd);
        return (cmd[7:4] == 4'b0100) && (!mdl[5][3] || cmd[3:1] == dev_sel);
    endfunction

    function automatic logic [7:0] step(input logic [7:0] a);
        if (mdl[5][5]) return a;
        return (a >= 8'd10) ? 8'd0 : a + 8'd1;
    endfunction

    task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
        if (a <= 8'd10 && a != 8'd7 && a != 8'd8) begin
            if (a == 8'd9) mdl[10] = d;
            else           mdl[a[3:0]] = d;
        end
    endtask

    task automatic spi_begin();
        spi_cs_n = 1'b0;
        spi_sck  = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic spi_end();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(HALF + 4);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nb,
                            output logic [7:0] rx, output logic oe_all);
        rx = 8'h00;
        oe_all = 1'b1;
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF);
            rx[i] = spi_miso;
            oe_all = oe_all & spi_miso_oe;
            spi_sck = 1'b1;
            wait_clk(HALF);
            spi_sck = 1'b0;
        end
    endtask

    // write burst of n bytes from wbuf, model updated when served
    task automatic do_write(input logic [7:0] cmd, input logic [7:0] a, input int n);
        logic [7:0] rx;
        logic oe;
        logic [7:0] p;
        logic ok;
        ok = accepts(cmd);
        p = a;
        spi_begin();
        spi_bits(cmd, 8, rx, oe);
        spi_bits(a, 8, rx, oe);
        for (int i = 0; i < n; i++) begin
            spi_bits(wbuf[i], 8, rx, oe);
            chk("R5", "miso_oe during write", {7'd0, oe}, 8'h00);
            if (ok) begin
                logic [7:0] nx;
                nx = step(p);
                mdl_write(p, wbuf[i]);
                p = nx;
            end
        end
        spi_end();
    endtask

    // read burst of n bytes into rbuf/obuf
    task automatic do_read(input logic [7:0] cmd, input logic [7:0] a, input int n);
        logic [7:0] rx;
        logic oe;
        spi_begin();
        spi_bits(cmd, 8, rx, oe);
        chk("R5", "miso_oe in command byte", {7'd0, spi_miso_oe}, 8'h00);
        spi_bits(a, 8, rx, oe);
        chk("R5", "miso_oe in address byte", {7'd0, oe}, 8'h00);
        for (int i = 0; i < n; i++) begin
            spi_bits(8'h00, 8, rbuf[i], obuf[i]);
        end
        spi_end();
        chk("R5", "miso_oe after frame", {7'd0, spi_miso_oe}, 8'h00);
    endtask

    // sequential read burst compared against the model
    task automatic read_cmp(input string req, input logic [7:0] sub,
                            input logic [7:0] a, input int n);
        logic [7:0] p;
        do_read({4'b0100, sub[2:0], 1'b1}, a, n);
        p = a;
        for (int i = 0; i < n; i++) begin
            chk(req, $sformatf("read @%02h", p), rbuf[i], exp_rd(p));
            chk("R5", "miso_oe in data byte", {7'd0, obuf[i]}, 8'h01);
            p = step(p);
        end
    endtask

    task automatic outs_cmp(input string req);
        chk(req, "pad_oe", pad_oe, ~mdl[0]);
        chk(req, "pad_out", pad_out, mdl[10]);
        chk(req, "pad_pull_en", pad_pull_en, mdl[6]);
        chk("R12", "irq_enable", irq_enable, mdl[2]);
        chk("R12", "irq_compare", irq_compare, mdl[3]);
        chk("R12", "irq_mode", irq_mode, mdl[4]);
        chk("R12", "cfg_bits", cfg_bits, mdl[5]);
    endtask

    initial begin
        for (int i = 0; i <= 10; i++) mdl[i] = 8'h00;
        mdl[0] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        chk("R1", "pad_oe", pad_oe, 8'h00);
        chk("R1", "miso_oe", {7'd0, spi_miso_oe}, 8'h00);
        outs_cmp("R1");
        read_cmp("R1", 8'd2, 8'h00, 11);

        // R4 / R8 / R12: single writes to every address, then read back
        for (int a = 0; a <= 10; a++) begin
            wbuf[0] = (a == 5) ? 8'h44 : 8'((a * 37 + 11) & 8'hFF);
            do_write({4'b0100, 3'(a), 1'b0}, 8'(a), 1);
        end
        outs_cmp("R8");
        for (int a = 0; a <= 10; a++) read_cmp("R4", 8'd1, 8'(a), 1);

        // R6: full burst and wrapping bursts
        read_cmp("R6", 8'd0, 8'h00, 11);
        read_cmp("R6", 8'd7, 8'h09, 14);
        wbuf[0] = 8'h5A; wbuf[1] = 8'h81; wbuf[2] = 8'h0F; wbuf[3] = 8'hE7;
        do_write(8'h40, 8'h09, 4);
        read_cmp("R6", 8'd0, 8'h00, 11);
        outs_cmp("R6");

        // R7: out-of-range addresses
        read_cmp("R7", 8'd0, 8'h20, 3);
        wbuf[0] = 8'hFF; wbuf[1] = 8'h12;
        do_write(8'h40, 8'h1F, 2);
        read_cmp("R7", 8'd0, 8'h00, 11);

        // R9: port read with polarity, port write to latch
        for (int k = 0; k < 4; k++) begin
            pad_in = 8'(8'h1D * (k + 1) + 8'h40);
            wbuf[0] = 8'(8'h33 << k);
            do_write(8'h40, 8'h01, 1);
            read_cmp("R9", 8'd0, 8'h09, 1);
        end
        wbuf[0] = 8'h6B;
        do_write(8'h40, 8'h09, 1);
        chk("R9", "latch after port write", pad_out, 8'h6B);

        // R10: flag and capture read-only views
        irq_flag_in = 8'h96; irq_cap_in = 8'h2E;
        wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
        do_write(8'h40, 8'h07, 2);
        read_cmp("R10", 8'd0, 8'h07, 2);
        outs_cmp("R10");

        // R2: wrong device codes ignored
        for (int c = 0; c < 16; c++) begin
            if (c == 4) continue;
            wbuf[0] = 8'(c);
            do_write({4'(c), 3'd0, 1'b0}, 8'h06, 1);
            chk("R2", "pull after bad code", pad_pull_en, mdl[6]);
        end
        do_read(8'h81, 8'h00, 1);
        chk("R2", "miso_oe bad code read", {7'd0, obuf[0]}, 8'h00);

        // R3: sub-address matching
        wbuf[0] = 8'h00;
        do_write(8'h4E, 8'h06, 1);
        chk("R3", "any sub-address when disabled", pad_pull_en, 8'h00);
        wbuf[0] = 8'h08;
        do_write(8'h42, 8'h05, 1);
        for (int s = 0; s < 8; s++) begin
            wbuf[0] = 8'(8'h10 + s);
            do_write({4'b0100, 3'(s), 1'b0}, 8'h06, 1);
            chk("R3", $sformatf("pull after sub %0d", s), pad_pull_en, mdl[6]);
            do_read({4'b0100, 3'(s), 1'b1}, 8'h06, 1);
            chk("R3", "miso_oe by sub match", {7'd0, obuf[0]}, (s == 5) ? 8'h01 : 8'h00);
        end
        chk("R3", "only matching sub wrote", pad_pull_en, 8'h15);

        // R6: no-increment set by the burst's own second byte
        wbuf[0] = 8'h11; wbuf[1] = 8'h28; wbuf[2] = 8'h77; wbuf[3] = 8'h99;
        do_write(8'h4A, 8'h04, 4);
        chk("R6", "mode byte", irq_mode, 8'h11);
        chk("R6", "cfg byte", cfg_bits, 8'h28);
        chk("R6", "pull last wins", pad_pull_en, 8'h99);
        read_cmp("R6", 8'd5, 8'h02, 3);
        read_cmp("R6", 8'd5, 8'h0A, 2);

        // R11: abort mid-byte
        begin
            logic [7:0] rx;
            logic oe;
            spi_begin();
            spi_bits(8'h4A, 8, rx, oe);
            spi_bits(8'h06, 8, rx, oe);
            spi_bits(8'hFF, 4, rx, oe);
            spi_end();
        end
        chk("R11", "pull after abort", pad_pull_en, 8'h99);
        wbuf[0] = 8'h3C;
        do_write(8'h4A, 8'h06, 1);
        chk("R11", "fresh frame after abort", pad_pull_en, 8'h3C);
        outs_cmp("R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule